// File: doc/BRIEF.md
# Layered Barrel Shifter with Shared Left-Shift Core

This block shifts a 16-bit operand by 0 to 15 places in one of three modes: logical left, logical right and arithmetic right. The shift distance is the low four bits of a second operand bus. The bits above those four play no part. An execution unit uses it as the shift path next to an adder. It presents the operand and the shift control, and reads the registered result one clock later.

Only one shift core exists, and it moves bits toward the most significant end. It has four stages that move the word by 1, 2, 4 and 8 positions. Each stage is switched on by one bit of the shift distance. For a right shift, the operand's bit order is mirrored before the core and mirrored again after it. Positions that a shift empties take a single fill bit. That bit is the operand's sign bit for an arithmetic right shift and zero in every other mode. Nothing is rotated around the word, and no bit that falls off the end is kept. The carry output of the unit is always low.

The result register is gated by an output enable. When the enable is low, the result reads as zero and the drive flag is low, so a shared result bus can merge this unit with others by OR. Reset is synchronous and active high.

Top module: `shf_barrel`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next values of `res_q`, `drive_q` and `carry_q` are all 0.
- R2: With `out_en`=1 and `dir_right`=0, `res_q` one clock later equals `op_a` shifted toward bit 15 by `op_b[3:0]` places, with zeros entering at bit 0.
- R3: With `out_en`=1, `dir_right`=1 and `arith`=0, `res_q` one clock later equals `op_a` shifted toward bit 0 by `op_b[3:0]` places, with zeros entering at bit 15.
- R4: With `out_en`=1, `dir_right`=1 and `arith`=1, `res_q` one clock later equals `op_a` shifted toward bit 0 by `op_b[3:0]` places, with copies of `op_a[15]` entering at bit 15.
- R5: With `dir_right`=0, the value of `arith` has no effect on `res_q`, so the result is the same as a logical left shift.
- R6: Bits `op_b[15:4]` have no effect on `res_q`.
- R7: A shift distance of 0 gives `res_q` equal to `op_a` in all three modes.
- R8: With `out_en`=0, the next `res_q` is 0 and the next `drive_q` is 0. With `out_en`=1 and `rst`=0, the next `drive_q` is 1.
- R9: `carry_q` is 0 in every cycle.
- R10: At the maximum distance of 15, a left shift leaves only `op_a[0]` at bit 15. An arithmetic right shift of an operand with bit 15 set gives 16'hFFFF. A logical right shift leaves only `op_a[15]` at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 16 | Operand to shift |
| op_b | input | 16 | Second operand bus; bits 3:0 give the shift distance |
| dir_right | input | 1 | 1 selects a shift toward bit 0 |
| arith | input | 1 | With dir_right=1, fills with the sign bit |
| out_en | input | 1 | Output enable for the result bus |
| res_q | output | 16 | Registered shifted result, 0 when not enabled |
| drive_q | output | 1 | Registered copy of the output enable |
| carry_q | output | 1 | Carry flag, always 0 |

## Verification
Every shift distance from 0 to 15 is applied in all three modes. The operands used are 16'h8000, 16'h7FFF, 16'hFFFF, 16'h0001 and random words. A lone top bit or lone bottom bit shows each stage's exact displacement and whether the mirror stages are active. Operands with the sign bit set and clear separate zero fill from sign fill. Setting random upper bits of the second operand shows that the distance decode reads only four bits, and asserting the arithmetic select on left shifts shows that the fill stays zero in that mode.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    SHF_LEFT  = 2'd0,
    SHF_LRGT  = 2'd1,
    SHF_ARGT  = 2'd2
  } shf_mode_e;

  function automatic shf_mode_e shf_decode(input logic right, input logic sign_ext);
    if (!right)       return SHF_LEFT;
    else if (sign_ext) return SHF_ARGT;
    else               return SHF_LRGT;
  endfunction

endpackage

// File: rtl/shf_reverse.sv
module shf_reverse #(
  parameter int WIDTH = 16
) (
  input  logic             en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] mirrored;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign mirrored[i] = din[WIDTH-1-i];
  end

  assign dout = en ? mirrored : din;

endmodule

// File: rtl/shf_layer.sv
module shf_layer #(
  parameter int WIDTH = 16,
  parameter int SHIFT = 1
) (
  input  logic             en,
  input  logic             fill,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] moved;

  assign moved = {din[WIDTH-1-SHIFT:0], {SHIFT{fill}}};
  assign dout  = en ? moved : din;

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
  import shf_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             dir_right,
  input  logic             arith,
  input  logic             out_en,
  output logic [WIDTH-1:0] res_q,
  output logic             drive_q,
  output logic             carry_q
);

  localparam int AMT_W = $clog2(WIDTH);

  shf_mode_e        mode;
  logic             mirror;
  logic             fill_bit;
  logic [AMT_W-1:0] amt;
  logic [WIDTH-1:0] pre_core;
  logic [WIDTH-1:0] post_core;
  logic [WIDTH-1:0] result;
  logic [WIDTH-1:0] stage [AMT_W+1];
  logic             unused_hi;

  assign mode      = shf_decode(dir_right, arith);
  assign mirror    = (mode != SHF_LEFT);
  assign fill_bit  = (mode == SHF_ARGT) ? op_a[WIDTH-1] : 1'b0;
  assign amt       = op_b[AMT_W-1:0];
  assign unused_hi = ^op_b[WIDTH-1:AMT_W];

  shf_reverse #(.WIDTH(WIDTH)) u_rev_in (
    .en   (mirror),
    .din  (op_a),
    .dout (pre_core)
  );

  assign stage[0] = pre_core;

  for (genvar i = 0; i < AMT_W; i++) begin : g_layer
    shf_layer #(.WIDTH(WIDTH), .SHIFT(1 << i)) u_layer (
      .en   (amt[i]),
      .fill (fill_bit),
      .din  (stage[i]),
      .dout (stage[i+1])
    );
  end

  assign post_core = stage[AMT_W];

  shf_reverse #(.WIDTH(WIDTH)) u_rev_out (
    .en   (mirror),
    .din  (post_core),
    .dout (result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      drive_q <= 1'b0;
      carry_q <= 1'b0;
    end else begin
      res_q   <= out_en ? result : '0;
      drive_q <= out_en;
      carry_q <= 1'b0;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (res_q == '0 && !drive_q && !carry_q)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(out_en)) |-> (res_q == '0 && !drive_q)); // R8

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(out_en) && $past(op_b[AMT_W-1:0]) == '0)
      |-> res_q == $past(op_a)); // R7

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(out_en) && $past(dir_right) && $past(arith))
      |-> res_q[WIDTH-1] == $past(op_a[WIDTH-1])); // R4

  AST_SRL_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(out_en) && $past(dir_right) && !$past(arith)
      && $past(op_b[AMT_W-1:0]) != '0) |-> !res_q[WIDTH-1]); // R3

  AST_SLL_LSB_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(out_en) && !$past(dir_right)
      && $past(op_b[AMT_W-1:0]) != '0) |-> !res_q[0]); // R2

endmodule

// File: tb/shf_barrel_bench.sv
module shf_barrel_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        dir_right = 1'b0;
  logic        arith = 1'b0;
  logic        out_en = 1'b0;
  logic [15:0] res_q;
  logic        drive_q;
  logic        carry_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10ns clk = ~clk;

  shf_barrel u_shf_barrel (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .dir_right(dir_right), .arith(arith), .out_en(out_en),
    .res_q(res_q), .drive_q(drive_q), .carry_q(carry_q)
  );

  function automatic logic [15:0] model(input logic [15:0] a, input int amt,
                                        input logic r, input logic s, input logic en);
    logic signed [15:0] sa;
    if (!en) return 16'h0000;
    sa = a;
    if (!r)     return a << amt;
    else if (s) return 16'(sa >>> amt);
    else        return a >> amt;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic [15:0] a, input logic [15:0] b,
                      input logic r, input logic s, input logic en);
    logic [15:0] exp;
    @(negedge clk);
    op_a = a; op_b = b; dir_right = r; arith = s; out_en = en;
    exp = model(a, int'(b[3:0]), r, s, en);
    @(posedge clk);
    @(negedge clk);
    chk(req, res_q, exp);
    chk({req, " drive"}, {15'd0, drive_q}, {15'd0, en});
    chk("R9 carry", {15'd0, carry_q}, 16'h0000);
  endtask

  initial begin
    logic [15:0] pats [5];
    pats[0] = 16'h8000; pats[1] = 16'h7FFF; pats[2] = 16'hFFFF; pats[3] = 16'h0001;
    out_en = 1'b1; op_a = 16'hA5A5; op_b = 16'h0003;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 res", res_q, 16'h0000);
    chk("R1 drive", {15'd0, drive_q}, 16'h0000);
    chk("R1 carry", {15'd0, carry_q}, 16'h0000);
    rst = 1'b0;

    for (int amt = 0; amt < 16; amt++) begin
      for (int k = 0; k < 6; k++) begin
        logic [15:0] a;
        string tag;
        pats[4] = 16'($urandom);
        a = pats[k % 5];
        if (k == 5) a = 16'($urandom);
        tag = (amt == 0) ? "R7" : (amt == 15) ? "R10" : "";
        step({"R2 ", tag}, a, 16'(amt), 1'b0, 1'b0, 1'b1);
        step({"R3 ", tag}, a, 16'(amt), 1'b1, 1'b0, 1'b1);
        step({"R4 ", tag}, a, 16'(amt), 1'b1, 1'b1, 1'b1);
        step("R5", a, 16'(amt), 1'b0, 1'b1, 1'b1);
        step("R6", a, {12'($urandom) | 12'h001, 4'(amt)}, 1'b1, 1'b1, 1'b1);
      end
    end

    step("R10 sll", 16'h0001, 16'd15, 1'b0, 1'b0, 1'b1);
    chk("R10 sll top", res_q, 16'h8000);
    step("R10 sra", 16'h8000, 16'd15, 1'b1, 1'b1, 1'b1);
    chk("R10 sra ones", res_q, 16'hFFFF);
    step("R10 srl", 16'h8000, 16'd15, 1'b1, 1'b0, 1'b1);
    chk("R10 srl one", res_q, 16'h0001);

    step("R8 off", 16'hFFFF, 16'd3, 1'b1, 1'b1, 1'b0);
    chk("R8 zero", res_q, 16'h0000);
    step("R8 on", 16'h1234, 16'd4, 1'b0, 1'b0, 1'b1);
    chk("R8 value", res_q, 16'h2340);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20ns);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule